// File: doc/BRIEF.md
# Character Bank Switching Cartridge Mapper

This block sits between an 8-bit CPU, a video chip and the two ROMs of a game cartridge. Program ROM is not banked: the upper half of the CPU address space maps straight onto it. Character ROM is split into 8 KB banks. Any CPU write into the upper half of the address space stores a bank number in one register. That register then supplies the high address lines for every video-chip fetch in its 8 KB pattern window.

The board has no write-enable logic on its ROM. During a write, the ROM therefore drives the bus together with the CPU. The value that gets stored is the AND of the CPU data and the ROM byte at the written address. A board-variant input turns this effect off. The stored byte can also be read out and written back directly, so that machine state can be saved and restored. A restore goes straight into the register and is never masked by the ROM byte.

Top module: `chr_bank_mapper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the stored bank byte is 0, so `chr_rom_addr` selects bank 0.
- R2: A CPU write with address bit 15 set (0x8000 to 0xFFFF) loads the bank byte on that clock edge. Every address in that range decodes the same way. With `conflict_off` = 1 the byte loaded is exactly `cpu_wdata`.
- R3: With `conflict_off` = 0, a CPU write in the upper range stores `cpu_wdata & rom_rdata`.
- R4: CPU writes with address bit 15 clear, including the work-RAM range 0x6000 to 0x7FFF, leave the bank byte unchanged.
- R5: `chr_rom_addr` equals {bank byte modulo CHR_BANKS, `ppu_addr[12:0]`}, combinationally from the register. With the default of 4 banks this means bank byte bits [1:0] on address bits [14:13].
- R6: `prg_rom_addr` equals `cpu_addr[14:0]` at all times, whatever the value of the bank byte.
- R7: `snap_q` always shows the raw 8-bit bank byte. A cycle with `snap_wr` = 1 loads `snap_data` unchanged, with no AND against the ROM byte, and takes effect on the next clock edge.
- R8: When `snap_wr` and a qualifying CPU write fall in the same cycle, the restore value wins.
- R9: `wram_sel` is 1 exactly when `cpu_addr` lies in 0x6000 to 0x7FFF (bits [15:13] = 3'b011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| rom_rdata | input | 8 | Program-ROM byte driven at `cpu_addr` |
| conflict_off | input | 1 | 1 disables bus-conflict masking |
| ppu_addr | input | 13 | Video-chip pattern-window address |
| snap_wr | input | 1 | Restore strobe for the bank byte |
| snap_data | input | 8 | Value to restore |
| prg_rom_addr | output | 15 | Program-ROM address |
| chr_rom_addr | output | 15 | Character-ROM address |
| wram_sel | output | 1 | Work-RAM window select |
| snap_q | output | 8 | Raw bank byte |

## Verification
The embedded assertions check five things on every cycle. The register is zero after reset. A low-address write never moves it. Conflict-masked loads contain no bit that the ROM byte lacked. A restore lands unchanged. The work-RAM select never overlaps the ROM range.

Only the bench's scenarios can show the rest. These are the exact values loaded across the address range, and the modulo wrap seen on the character address lines. They also cover the restore-over-write priority and the fact that program-ROM addressing stays linear whatever bank is selected.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  // Value seen on the shared data bus during a ROM-area write
  function automatic byte_t bus_resolve(input byte_t cpu_d, input byte_t rom_d,
                                        input logic bypass);
    return bypass ? cpu_d : (cpu_d & rom_d);
  endfunction

  // Bank index after wrapping onto a power-of-two bank count
  function automatic byte_t bank_wrap(input byte_t raw, input int unsigned banks);
    return raw & byte_t'(banks - 1);
  endfunction
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode #(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned PRG_AW = 15
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  output logic              load_hit,
  output logic              wram_sel,
  output logic [PRG_AW-1:0] prg_rom_addr
);
  localparam logic [2:0] WRAM_TAG = 3'b011;

  always_comb begin
    load_hit     = cpu_we & cpu_addr[CPU_AW-1];
    wram_sel     = (cpu_addr[CPU_AW-1 -: 3] == WRAM_TAG);
    prg_rom_addr = cpu_addr[PRG_AW-1:0];
  end
endmodule

// File: rtl/bank_reg.sv
module bank_reg
  import chr_map_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_hit,
  input  logic  low_write,
  input  byte_t cpu_wdata,
  input  byte_t rom_rdata,
  input  logic  conflict_off,
  input  logic  snap_wr,
  input  byte_t snap_data,
  output byte_t bank_q
);
  byte_t bus_val;

  always_comb bus_val = bus_resolve(cpu_wdata, rom_rdata, conflict_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bank_q <= '0;
    else if (snap_wr)  bank_q <= snap_data;
    else if (load_hit) bank_q <= bus_val;
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> bank_q == '0); // R1
  AST_LOW_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (low_write && !snap_wr) |=> $stable(bank_q)); // R4
  AST_CONFLICT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && !snap_wr && !conflict_off) |=> (bank_q & ~$past(rom_rdata)) == '0); // R3
  AST_RESTORE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> bank_q == $past(snap_data)); // R7
endmodule

// File: rtl/chr_addr_gen.sv
module chr_addr_gen
  import chr_map_pkg::*;
#(
  parameter int unsigned CHR_BANKS  = 4,
  parameter int unsigned CHR_WIN_AW = 13
) (
  input  byte_t                      bank_q,
  input  logic [CHR_WIN_AW-1:0]      ppu_addr,
  output logic [CHR_WIN_AW+$clog2(CHR_BANKS)-1:0] chr_rom_addr
);
  localparam int unsigned SEL_W = $clog2(CHR_BANKS);

  byte_t wrapped;
  always_comb begin
    wrapped      = bank_wrap(bank_q, CHR_BANKS);
    chr_rom_addr = {wrapped[SEL_W-1:0], ppu_addr};
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int unsigned CPU_AW     = 16,
  parameter int unsigned PRG_AW     = 15,
  parameter int unsigned CHR_BANKS  = 4,
  parameter int unsigned CHR_WIN_AW = 13,
  localparam int unsigned CHR_AW    = CHR_WIN_AW + $clog2(CHR_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CPU_AW-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  input  logic                  cpu_we,
  input  logic [DATA_W-1:0]     rom_rdata,
  input  logic                  conflict_off,
  input  logic [CHR_WIN_AW-1:0] ppu_addr,
  input  logic                  snap_wr,
  input  logic [DATA_W-1:0]     snap_data,
  output logic [PRG_AW-1:0]     prg_rom_addr,
  output logic [CHR_AW-1:0]     chr_rom_addr,
  output logic                  wram_sel,
  output logic [DATA_W-1:0]     snap_q
);
  logic  load_hit;
  logic  low_write;
  byte_t bank_q;

  cpu_decode #(.CPU_AW(CPU_AW), .PRG_AW(PRG_AW)) u_dec (
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .load_hit(load_hit),
    .wram_sel(wram_sel), .prg_rom_addr(prg_rom_addr)
  );

  always_comb low_write = cpu_we & ~cpu_addr[CPU_AW-1];

  bank_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load_hit(load_hit), .low_write(low_write),
    .cpu_wdata(cpu_wdata), .rom_rdata(rom_rdata), .conflict_off(conflict_off),
    .snap_wr(snap_wr), .snap_data(snap_data), .bank_q(bank_q)
  );

  chr_addr_gen #(.CHR_BANKS(CHR_BANKS), .CHR_WIN_AW(CHR_WIN_AW)) u_chr (
    .bank_q(bank_q), .ppu_addr(ppu_addr), .chr_rom_addr(chr_rom_addr)
  );

  always_comb snap_q = bank_q;

  AST_WRAM_NOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    wram_sel |-> !cpu_addr[CPU_AW-1]); // R9
endmodule

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr[15:0], wdata[7:0], rom[7:0], off, expected raw[7:0]}
  localparam logic [40:0] TBL [NV] = '{
    {16'h8000, 8'h5A, 8'hFF, 1'b1, 8'h5A},  // R2
    {16'hFFFF, 8'h3C, 8'h0F, 1'b0, 8'h0C},  // R3
    {16'hA5A5, 8'hF3, 8'h33, 1'b0, 8'h33},  // R3
    {16'hC000, 8'h81, 8'h00, 1'b1, 8'h81},  // R2
    {16'h7FFF, 8'h22, 8'hFF, 1'b1, 8'h81},  // R4
    {16'h6000, 8'h00, 8'hFF, 1'b1, 8'h81},  // R4
    {16'h9000, 8'h07, 8'h05, 1'b0, 8'h05},  // R3
    {16'h0000, 8'hFF, 8'hFF, 1'b1, 8'h05}   // R4
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, rom_rdata = '0, snap_data = '0;
  logic cpu_we = 0, conflict_off = 0, snap_wr = 0;
  logic [12:0] ppu_addr = '0;
  logic [14:0] prg_rom_addr, chr_rom_addr;
  logic wram_sel;
  logic [7:0] snap_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .rom_rdata(rom_rdata), .conflict_off(conflict_off),
    .ppu_addr(ppu_addr), .snap_wr(snap_wr), .snap_data(snap_data),
    .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
    .wram_sel(wram_sel), .snap_q(snap_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                           input logic [7:0] r, input logic off);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; rom_rdata = r; conflict_off = off; cpu_we = 1;
    @(negedge clk);
    cpu_we = 0;
  endtask

  function automatic logic [14:0] chr_exp(input logic [7:0] raw, input logic [12:0] p);
    return {raw % 8'd4, p} ;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset raw", snap_q, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bank after reset", chr_rom_addr[14:13], 2'd0);

    for (int i = 0; i < NV; i++) begin
      cpu_write(TBL[i][40:25], TBL[i][24:17], TBL[i][16:9], TBL[i][8]);
      ppu_addr = 13'h1ABC ^ 13'(i * 37);
      #1;
      chk($sformatf("R2/R3/R4 vec%0d raw", i), snap_q, TBL[i][7:0]);
      chk($sformatf("R5 vec%0d chr", i), chr_rom_addr, chr_exp(TBL[i][7:0], ppu_addr));
    end

    // R6: linear program ROM, independent of bank
    cpu_addr = 16'hD123; #1;
    chk("R6 prg addr", prg_rom_addr, 15'h5123);
    cpu_addr = 16'h8000; #1;
    chk("R6 prg addr low", prg_rom_addr, 15'h0000);

    // R9: work RAM window
    cpu_addr = 16'h6000; #1; chk("R9 wram lo", wram_sel, 1'b1);
    cpu_addr = 16'h7FFF; #1; chk("R9 wram hi", wram_sel, 1'b1);
    cpu_addr = 16'h5FFF; #1; chk("R9 below", wram_sel, 1'b0);
    cpu_addr = 16'h8000; #1; chk("R9 rom", wram_sel, 1'b0);

    // R5 wrap: 0xFF with 4 banks selects bank 3
    cpu_write(16'hBEEF, 8'hFF, 8'hFF, 1'b1);
    ppu_addr = 13'h0000; #1;
    chk("R5 wrap", chr_rom_addr, 15'h6000);
    ppu_addr = 13'h1FFF; #1;
    chk("R5 top of window", chr_rom_addr, 15'h7FFF);

    // R7: restore ignores conflict setting and ROM byte
    @(negedge clk);
    conflict_off = 0; rom_rdata = 8'h00; snap_data = 8'hE6; snap_wr = 1;
    @(negedge clk);
    snap_wr = 0; #1;
    chk("R7 restore exact", snap_q, 8'hE6);
    chk("R7 restore bank", chr_rom_addr[14:13], 2'd2);

    // R8: restore beats simultaneous CPU write
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_wdata = 8'h01; rom_rdata = 8'hFF; conflict_off = 1;
    cpu_we = 1; snap_wr = 1; snap_data = 8'h42;
    @(negedge clk);
    cpu_we = 0; snap_wr = 0; #1;
    chk("R8 restore priority", snap_q, 8'h42);

    // R1: reset mid-run clears register
    rst_n = 0; #1;
    chk("R1 async reset", snap_q, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 stays zero", chr_rom_addr[14:13], 2'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule